// File: doc/BRIEF.md
# Masked multi-source interrupt level controller

This block gathers level-sensitive interrupt requests from error detectors, on-board devices and two groups of seven bus priority lines. It turns them into one 4-bit processor interrupt level per processor. Each global source has its own mask bit. A set bit blocks the source. A master bit blocks every global source at once. Software never writes the mask directly: one address masks the bits written as 1, and another address unmasks them.

Each processor also owns a register of software interrupt requests, levels 1 to 15, together with an enable for its local level-14 tick input. A target register picks the single processor that receives the global sources. Every processor's output shows the highest level that is active for it, or 0 when nothing is active.

The 32-bit register port is word-addressed. A write takes effect on the clock edge where `wr_en` is high. Reads are combinational. Level outputs are registered, so they reflect the state and inputs of the previous cycle.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset the mask holds all implemented bits set (0xF87FFFFF, master bit 31 included), the target is processor 0, every per-processor register is 0 and every level output is 0.
- R2: A write to address 2 sets each implemented mask bit whose data bit is 1 and leaves the others unchanged; address 1 reads the mask.
- R3: A write to address 3 clears each mask bit whose data bit is 1 and leaves the others unchanged.
- R4: While mask bit 31 is 1, no global source reaches any level output.
- R5: Sources on bits 30, 29, 28 and 27 give level 15. The on-board bits give: bit 22 level 11, bit 21 level 9, bit 20 level 8, bit 19 level 10, bit 18 level 4, bit 17 level 13, bit 16 level 6, bits 15 and 14 level 12.
- R6: Bus line n (0..6) sits at bit n+7 in one group and at bit n in the other, and gives level 2, 3, 5, 7, 9, 11 or 13 for n = 0..6.
- R7: Address 0 reads the raw global source inputs on the implemented bits (0x787FFFFF), whatever the mask holds.
- R8: Processor c has registers at 8+4c (read), 9+4c (write-one-to-set) and 10+4c (write-one-to-clear). Bit n+16 set requests software level n (1..15).
- R9: Bit 7 of a processor's register enables that processor's tick input. While it is enabled and the tick is high, the processor sees level 14.
- R10: Address 4 holds the target processor number. Only that processor sees the global sources.
- R11: Each output `cpu_pil[4c+3:4c]` equals the highest active level for processor c, or 0 when none is active, one clock after the causing state or input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| dev_irq | input | 32 | Global level request lines |
| cpu_tick | input | NCPU | Per-processor level-14 tick |
| cpu_pil | output | 4*NCPU | Per-processor interrupt level |

## Verification
Directed sweeps raise one global source at a time with everything unmasked. These sweeps separate each bit's level assignment, including the two bus groups, which share levels but sit at different bits. Master-mask and target-switch cases show whether gating is global or per-processor. Random mixes of mask writes, soft-request writes, tick changes and source changes put several levels up at once. Those mixes are compared with a bench model and expose errors in the priority choice and in the set/clear aliasing.

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl #(
  parameter int NCPU = 4,
  parameter int AW   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [31:0]       dev_irq,
  input  logic [NCPU-1:0]   cpu_tick,
  output logic [4*NCPU-1:0] cpu_pil
);
  localparam int TW = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam logic [31:0] MASK_IMPL = 32'hF87F_FFFF;
  localparam logic [31:0] SRC_IMPL  = 32'h787F_FFFF;
  localparam logic [31:0] PC_IMPL   = 32'hFFFE_0080;
  localparam int A_PEND = 0, A_MASK = 1, A_MSET = 2, A_MCLR = 3, A_TGT = 4, PC_BASE = 8;

  function automatic logic [3:0] bus_lvl(input int n);
    return (n == 0) ? 4'd2 : 4'(2 * n + 1);
  endfunction

  function automatic logic [3:0] src_lvl(input int i);
    case (i)
      30, 29, 28, 27: return 4'd15;
      22: return 4'd11;
      21: return 4'd9;
      20: return 4'd8;
      19: return 4'd10;
      18: return 4'd4;
      17: return 4'd13;
      16: return 4'd6;
      15, 14: return 4'd12;
      default: return (i >= 7 && i <= 13) ? bus_lvl(i - 7) : (i <= 6) ? bus_lvl(i) : 4'd0;
    endcase
  endfunction

  logic [31:0]   mask_q;
  logic [TW-1:0] tgt_q;
  logic [31:0]   soft_q [NCPU];
  logic [31:0]   pend, act;
  logic [15:0]   g_hit;

  assign pend = dev_irq & SRC_IMPL;
  assign act  = pend & ~mask_q & {32{~mask_q[31]}};

  always_comb begin
    g_hit = '0;
    for (int i = 0; i < 31; i++)
      if (act[i]) g_hit[src_lvl(i)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= MASK_IMPL;
      tgt_q  <= '0;
    end else if (wr_en) begin
      if (addr == AW'(A_MSET)) mask_q <= mask_q | (wdata & MASK_IMPL);
      if (addr == AW'(A_MCLR)) mask_q <= mask_q & ~wdata;
      if (addr == AW'(A_TGT))  tgt_q  <= wdata[TW-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(A_PEND): rdata = pend;
      AW'(A_MASK): rdata = mask_q;
      AW'(A_TGT):  rdata = 32'(tgt_q);
      default: ;
    endcase
    for (int c = 0; c < NCPU; c++)
      if (addr == AW'(PC_BASE + 4 * c)) rdata = soft_q[c];
  end

  generate
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      logic [15:0] hit;
      logic [3:0]  pil_d;

      assign hit = (g_hit & {16{tgt_q == TW'(c)}})
                 | {soft_q[c][31:17], 1'b0}
                 | {1'b0, soft_q[c][7] & cpu_tick[c], 14'd0};

      always_comb begin
        pil_d = '0;
        for (int l = 1; l < 16; l++)
          if (hit[l]) pil_d = 4'(l);
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          soft_q[c]        <= '0;
          cpu_pil[4*c +: 4] <= '0;
        end else begin
          cpu_pil[4*c +: 4] <= pil_d;
          if (wr_en && addr == AW'(PC_BASE + 4 * c + 1)) soft_q[c] <= soft_q[c] | (wdata & PC_IMPL);
          if (wr_en && addr == AW'(PC_BASE + 4 * c + 2)) soft_q[c] <= soft_q[c] & ~wdata;
        end
      end

      a_r4_master_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[31] && soft_q[c][31:17] == '0 && !(soft_q[c][7] && cpu_tick[c]))
        |=> cpu_pil[4*c +: 4] == 4'd0);

      a_r10_not_target: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_q != TW'(c) && soft_q[c][31:17] == '0 && !(soft_q[c][7] && cpu_tick[c]))
        |=> cpu_pil[4*c +: 4] == 4'd0);

      a_r8_soft15_top: assert property (@(posedge clk) disable iff (!rst_n)
        soft_q[c][31] |=> cpu_pil[4*c +: 4] == 4'd15);
    end
  endgenerate

  a_r2_set_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(A_MSET)) |=> (mask_q & $past(wdata & MASK_IMPL)) == $past(wdata & MASK_IMPL));

  a_r3_clear_unmasks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(A_MCLR)) |=> (mask_q & $past(wdata)) == 32'd0);

  a_r3_other_cycles_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == AW'(A_MSET) || addr == AW'(A_MCLR))) |=> $stable(mask_q));
endmodule

// File: tb/tb_irq_level_ctrl.sv
module tb_irq_level_ctrl;
  localparam int NCPU = 4, AW = 5;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata, dev_irq = '0;
  logic [NCPU-1:0] cpu_tick = '0;
  logic [4*NCPU-1:0] cpu_pil;
  int total = 0, bad = 0;

  logic [31:0] m_mask, m_soft [NCPU];
  int m_tgt;

  irq_level_ctrl #(.NCPU(NCPU), .AW(AW)) dut (.*);

  always #2.5 clk = ~clk;

  initial begin
    #900000;
    bad++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int exp_lvl(int i);
    int bl [7] = '{2, 3, 5, 7, 9, 11, 13};
    if (i >= 27 && i <= 30) return 15;
    case (i)
      22: return 11; 21: return 9; 20: return 8; 19: return 10;
      18: return 4;  17: return 13; 16: return 6; 15: return 12; 14: return 12;
      default: ;
    endcase
    if (i >= 7 && i <= 13) return bl[i-7];
    if (i <= 6) return bl[i];
    return 0;
  endfunction

  function automatic int exp_pil(int c);
    int best = 0;
    for (int i = 0; i < 31; i++)
      if (dev_irq[i] && !m_mask[i] && !m_mask[31] && m_tgt == c && exp_lvl(i) > best) best = exp_lvl(i);
    for (int n = 1; n < 16; n++)
      if (m_soft[c][n+16] && n > best) best = n;
    if (m_soft[c][7] && cpu_tick[c] && best < 14) best = 14;
    return best;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 0;
    if (a == 2) m_mask = m_mask | (d & 32'hF87F_FFFF);
    if (a == 3) m_mask = m_mask & ~d;
    if (a == 4) m_tgt = int'(d[1:0]);
    for (int c = 0; c < NCPU; c++) begin
      if (a == 9 + 4*c)  m_soft[c] = m_soft[c] | (d & 32'hFFFE_0080);
      if (a == 10 + 4*c) m_soft[c] = m_soft[c] & ~d;
    end
  endtask

  task automatic rd_chk(string req, int a, logic [31:0] exp);
    addr = AW'(a); #1;
    chk(req, rdata, exp);
  endtask

  task automatic pil_chk(string req);
    @(negedge clk);
    for (int c = 0; c < NCPU; c++) chk(req, 32'(cpu_pil[4*c +: 4]), 32'(exp_pil(c)));
  endtask

  initial begin
    void'($urandom(1234));
    m_mask = 32'hF87F_FFFF; m_tgt = 0;
    for (int c = 0; c < NCPU; c++) m_soft[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd_chk("R1", 1, 32'hF87F_FFFF);
    rd_chk("R1", 4, 0);
    for (int c = 0; c < NCPU; c++) rd_chk("R1", 8 + 4*c, 0);
    chk("R1", 32'(cpu_pil), 0);
    // R4 master blocks all
    dev_irq = 32'hFFFF_FFFF;
    wr(3, 32'h7FFF_FFFF);
    pil_chk("R4");
    chk("R4", 32'(cpu_pil), 0);
    // R7 raw pending
    rd_chk("R7", 0, 32'h787F_FFFF);
    // R3 clear keeps others
    wr(3, 32'h8000_0000);
    rd_chk("R3", 1, 0);
    // R5/R6 sweep each source
    for (int i = 0; i < 31; i++) begin
      dev_irq = 32'(1) << i;
      pil_chk((i >= 14) ? "R5" : "R6");
    end
    // R2 set partial
    wr(2, 32'h0004_0001);
    rd_chk("R2", 1, 32'h0004_0001);
    dev_irq = 32'h0004_0001;
    pil_chk("R2");
    // R10 target switch
    dev_irq = 32'h4000_0000;
    for (int t = 0; t < NCPU; t++) begin
      wr(4, 32'(t));
      rd_chk("R10", 4, 32'(t));
      pil_chk("R10");
    end
    // R8 soft levels, R9 tick
    wr(9 + 4*2, 32'h0010_0000);
    pil_chk("R8");
    rd_chk("R8", 8 + 4*2, 32'h0010_0000);
    cpu_tick = '1;
    pil_chk("R9");
    wr(9 + 4*1, 32'h0000_0080);
    pil_chk("R9");
    wr(10 + 4*1, 32'h0000_0080);
    pil_chk("R9");
    // R11 random mix
    for (int k = 0; k < 400; k++) begin
      int op = $urandom_range(0, 6);
      int c = $urandom_range(0, NCPU-1);
      logic [31:0] r = $urandom;
      case (op)
        0: wr(2, r & $urandom);
        1: wr(3, r);
        2: wr(4, 32'(c));
        3: wr(9 + 4*c, r & $urandom & $urandom);
        4: wr(10 + 4*c, r);
        5: begin @(negedge clk); dev_irq = r & $urandom; end
        default: begin @(negedge clk); cpu_tick = NCPU'($urandom); end
      endcase
      pil_chk("R11");
      if (k % 16 == 0) begin
        rd_chk("R2", 1, m_mask);
        rd_chk("R7", 0, dev_irq & 32'h787F_FFFF);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule